// File: doc/BRIEF.md
# Serial Flash Write-Protect Controller

This block decides whether a command that modifies a serial NOR flash may go ahead. It holds the protection part of the status register and the write-enable latch. Each command is one-cycle `cmdValid` pulse with a command code, a target address and, for a status write, a new status byte. Exactly one cycle later the block answers with an accept pulse or a reject pulse. An accepted command is handed on to the program and erase engine, which is outside this block. A rejected command changes nothing except the write-enable latch.

There are two layers of protection. Software protection uses four block-protect bits, which mark an upper part of the array as read-only. Hardware protection turns on when the status-register-write-disable bit is set and the write-protect pin is low, in either order. While it is on, the status register is frozen. Only a high level on the pin ends it. While the device runs in quad I/O read mode, the pin carries data, so hardware protection is switched off for that time.

Top module: `wp_ctrl_top`

## Requirements
- R1: After reset, `statusWord` is 0x00, `hpmActive` is 0, `cmdAccept` and `cmdReject` are 0, and `srLocked` is 1.
- R2: Command code 0 sets the write-enable latch (`statusWord` bit 1) and code 1 clears it. Both are always accepted.
- R3: `protHit` follows `cmdAddr` combinationally. With code c = `statusWord[5:2]` and block index b = `cmdAddr[ADDR_W-1:BLOCK_W]` (32 blocks by default), the address is protected when c is nonzero and b >= 32 - min(2^(c-1), 32). Code 0 protects nothing, and codes 6 to 15 protect the whole array.
- R4: Program (code 3) and erase (code 4) are accepted only when the write-enable latch is set and `protHit` is 0. Otherwise they are rejected. In both cases the latch reads 0 in the next cycle.
- R5: A status write (code 2) is accepted only when the latch is set and `hpmActive` is 0. When accepted, it loads `srData` bit 7 into `statusWord` bit 7 (the write-disable bit) and `srData[5:2]` into `statusWord[5:2]`. A rejected status write leaves bits 7 and 5:2 unchanged. The latch is cleared in both cases.
- R6: `hpmActive` goes high when bit 7 is 1 and `wpN` is low, whichever came first. This happens within 3 cycles of a `wpN` change, or 1 cycle after the status write.
- R7: Once `hpmActive` is high, it stays high until `wpN` is seen high or quad mode starts.
- R8: While `quadMode` is 1, `hpmActive` is 0 from the next cycle on, and `wpN` has no effect on it.
- R9: While `wpN` is held high, a status write with the latch set is accepted even when bit 7 is 1.
- R10: `srLocked` is 1 exactly when `hpmActive` is 1 or the write-enable latch is 0.
- R11: Every `cmdValid` cycle gives exactly one of `cmdAccept` or `cmdReject` in the next cycle, and neither pulses otherwise. Codes 5 to 7 are rejected and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wpN | input | 1 | Write-protect pin level, asynchronous |
| quadMode | input | 1 | Quad I/O read mode active |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdKind | input | 3 | Command code: 0 set latch, 1 clear latch, 2 status write, 3 program, 4 erase |
| cmdAddr | input | ADDR_W | Target byte address |
| srData | input | 8 | New status byte for a status write |
| statusWord | output | 8 | bit 7 write-disable, bits 5:2 block-protect code, bit 1 write-enable latch |
| protHit | output | 1 | `cmdAddr` lies in the protected region |
| srLocked | output | 1 | A status write would currently be rejected |
| hpmActive | output | 1 | Hardware protection in force |
| cmdAccept | output | 1 | Command accepted, one cycle after `cmdValid` |
| cmdReject | output | 1 | Command rejected, one cycle after `cmdValid` |

## Verification
The assertions assume that `cmdValid` is a single-cycle strobe and that `cmdKind` is stable while it is high. They also assume that `wpN` and `quadMode` stay at one level long enough for the synchronizer to see them. The stimulus drives every input half a cycle away from the active edge. It lowers `cmdValid` after each command. After any change to the pin or the quad mode, it waits four cycles before it compares `hpmActive`, so that expected values are only taken from settled state.

// File: rtl/wp_ctrl_pkg.sv
package wp_ctrl_pkg;

  typedef enum logic [2:0] {
    CMD_SET_WEL = 3'd0,
    CMD_CLR_WEL = 3'd1,
    CMD_WR_SR   = 3'd2,
    CMD_PROG    = 3'd3,
    CMD_ERASE   = 3'd4
  } cmdKind_e;

  localparam int SR_WIDTH    = 8;
  localparam int SR_LOCK_BIT = 7;
  localparam int BP_LSB      = 2;
  localparam int BP_WIDTH    = 4;
  localparam int WEL_BIT     = 1;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
  } ctrlStrobe_t;

endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode
  import wp_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int BLOCK_W = 16
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BP_WIDTH-1:0] bpCode,
  output logic                hit
);
  localparam int NBLK_W = ADDR_W - BLOCK_W;
  localparam logic [NBLK_W:0] NBLK = (NBLK_W+1)'(1) << NBLK_W;

  logic [NBLK_W-1:0] blockIdx;
  logic [NBLK_W:0]   protCount;
  logic [NBLK_W:0]   firstProt;

  assign blockIdx = addr[ADDR_W-1:BLOCK_W];

  always_comb begin
    if (bpCode == '0) begin
      protCount = '0;
    end else if ((int'(bpCode) - 1) >= NBLK_W) begin
      protCount = NBLK;
    end else begin
      protCount = (NBLK_W+1)'(1) << (bpCode - BP_WIDTH'(1));
    end
    firstProt = NBLK - protCount;
  end

  assign hit = (bpCode != '0) && ({1'b0, blockIdx} >= firstProt);

endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int BLOCK_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wpN,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [SR_WIDTH-1:0] srData,
  input  ctrlStrobe_t         strobe,
  output logic                srLockBit,
  output logic                welBit,
  output logic                wpHighSync,
  output logic                protHit,
  output logic [SR_WIDTH-1:0] statusWord
);
  logic [BP_WIDTH-1:0] bpReg;
  logic                lockReg;
  logic                welReg;

  // Pin synchronizer, resets to the unprotected (high) level
  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[SYNC_STAGES-2:0], wpN};
      end
      assign wpHighSync = chain[SYNC_STAGES-1];
    end else begin : gSyncSingle
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b1;
        else       stage <= wpN;
      end
      assign wpHighSync = stage;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockReg <= 1'b0;
      bpReg   <= '0;
    end else if (strobe.loadSr) begin
      lockReg <= srData[SR_LOCK_BIT];
      bpReg   <= srData[BP_LSB +: BP_WIDTH];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              welReg <= 1'b0;
    else if (strobe.setWel) welReg <= 1'b1;
    else if (strobe.clrWel) welReg <= 1'b0;
  end

  wp_region_decode #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) uDecode (
    .addr   (cmdAddr),
    .bpCode (bpReg),
    .hit    (protHit)
  );

  always_comb begin
    statusWord                      = '0;
    statusWord[SR_LOCK_BIT]         = lockReg;
    statusWord[BP_LSB +: BP_WIDTH]  = bpReg;
    statusWord[WEL_BIT]             = welReg;
  end

  assign srLockBit = lockReg;
  assign welBit    = welReg;

endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        quadMode,
  input  logic        cmdValid,
  input  logic [2:0]  cmdKind,
  input  logic        welBit,
  input  logic        srLockBit,
  input  logic        wpHighSync,
  input  logic        protHit,
  output ctrlStrobe_t strobe,
  output logic        hpmActive,
  output logic        srLocked,
  output logic        cmdAccept,
  output logic        cmdReject
);
  logic hpmReg;
  logic grant;
  ctrlStrobe_t rawStrobe;

  // Protection latch: set by lock bit with low pin, cleared only by pin high or quad mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        hpmReg <= 1'b0;
    else if (quadMode || wpHighSync)  hpmReg <= 1'b0;
    else if (srLockBit)               hpmReg <= 1'b1;
  end

  always_comb begin
    rawStrobe = '0;
    grant     = 1'b0;
    case (cmdKind)
      CMD_SET_WEL: begin
        grant            = 1'b1;
        rawStrobe.setWel = 1'b1;
      end
      CMD_CLR_WEL: begin
        grant            = 1'b1;
        rawStrobe.clrWel = 1'b1;
      end
      CMD_WR_SR: begin
        grant            = welBit && !hpmReg;
        rawStrobe.loadSr = grant;
        rawStrobe.clrWel = 1'b1;
      end
      CMD_PROG, CMD_ERASE: begin
        grant            = welBit && !protHit;
        rawStrobe.clrWel = 1'b1;
      end
      default: grant = 1'b0;
    endcase
  end

  assign strobe = cmdValid ? rawStrobe : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      cmdAccept <= cmdValid && grant;
      cmdReject <= cmdValid && !grant;
    end
  end

  assign hpmActive = hpmReg;
  assign srLocked  = hpmReg || !welBit;

endmodule

// File: rtl/wp_ctrl_top.sv
module wp_ctrl_top
  import wp_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int BLOCK_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              quadMode,
  input  logic              cmdValid,
  input  logic [2:0]        cmdKind,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        srData,
  output logic [7:0]        statusWord,
  output logic              protHit,
  output logic              srLocked,
  output logic              hpmActive,
  output logic              cmdAccept,
  output logic              cmdReject
);
  ctrlStrobe_t strobe;
  logic welBit;
  logic srLockBit;
  logic wpHighSync;

  wp_datapath #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .wpN        (wpN),
    .cmdAddr    (cmdAddr),
    .srData     (srData),
    .strobe     (strobe),
    .srLockBit  (srLockBit),
    .welBit     (welBit),
    .wpHighSync (wpHighSync),
    .protHit    (protHit),
    .statusWord (statusWord)
  );

  wp_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .quadMode   (quadMode),
    .cmdValid   (cmdValid),
    .cmdKind    (cmdKind),
    .welBit     (welBit),
    .srLockBit  (srLockBit),
    .wpHighSync (wpHighSync),
    .protHit    (protHit),
    .strobe     (strobe),
    .hpmActive  (hpmActive),
    .srLocked   (srLocked),
    .cmdAccept  (cmdAccept),
    .cmdReject  (cmdReject)
  );

endmodule

// File: rtl/wp_ctrl_checker.sv
module wp_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       quadMode,
  input logic       cmdValid,
  input logic [2:0] cmdKind,
  input logic [7:0] statusWord,
  input logic       protHit,
  input logic       hpmActive,
  input logic       wpHighSync,
  input logic       cmdAccept,
  input logic       cmdReject
);
  assert_one_answer_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (cmdAccept != cmdReject));

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (!cmdAccept && !cmdReject));

  assert_frozen_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hpmActive && cmdValid && cmdKind == 3'd2) |=> (cmdReject && $stable(statusWord[7:2])));

  assert_protected_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdKind == 3'd3 || cmdKind == 3'd4) && protHit) |=> (cmdReject && !statusWord[1]));

  assert_quad_disables_R8: assert property (@(posedge clk) disable iff (!rstN)
    quadMode |=> !hpmActive);

  assert_exit_by_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hpmActive) |-> ($past(quadMode) || $past(wpHighSync)));

endmodule

bind wp_ctrl_top wp_ctrl_checker uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .quadMode   (quadMode),
  .cmdValid   (cmdValid),
  .cmdKind    (cmdKind),
  .statusWord (statusWord),
  .protHit    (protHit),
  .hpmActive  (hpmActive),
  .wpHighSync (wpHighSync),
  .cmdAccept  (cmdAccept),
  .cmdReject  (cmdReject)
);

// File: tb/tb_wp_ctrl_top.sv
module tb_wp_ctrl_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 21;
  localparam int BLOCK_W    = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wpN = 1'b1;
  logic              quadMode = 1'b0;
  logic              cmdValid = 1'b0;
  logic [2:0]        cmdKind = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0]        srData = '0;
  logic [7:0]        statusWord;
  logic              protHit, srLocked, hpmActive, cmdAccept, cmdReject;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  logic       eLock = 0;
  logic [3:0] eBp   = 0;
  logic       eWel  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_ctrl_top #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .wpN(wpN), .quadMode(quadMode), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .srData(srData), .statusWord(statusWord),
    .protHit(protHit), .srLocked(srLocked), .hpmActive(hpmActive),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject)
  );

  function automatic logic expHit(logic [ADDR_W-1:0] a, logic [3:0] c);
    int blk  = int'(a >> BLOCK_W);
    int nblk = 1 << (ADDR_W - BLOCK_W);
    int size;
    if (c == 0) return 1'b0;
    size = (int'(c) - 1 >= ADDR_W - BLOCK_W) ? nblk : (1 << (int'(c) - 1));
    return blk >= nblk - size;
  endfunction

  function automatic logic [7:0] expStatus();
    return {eLock, 1'b0, eBp, eWel, 1'b0};
  endfunction

  function automatic logic expHpm();
    return eLock && !wpN && !quadMode;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    check("R6/R7/R8 hpmActive", 32'(hpmActive), 32'(expHpm()));
    check("R10 srLocked", 32'(srLocked), 32'(expHpm() || !eWel));
  endtask

  task automatic issue(logic [2:0] kind, logic [ADDR_W-1:0] addr, logic [7:0] data);
    logic ok;
    @(negedge clk);
    cmdKind = kind; cmdAddr = addr; srData = data; cmdValid = 1'b1;
    #1;
    check("R3 protHit", 32'(protHit), 32'(expHit(addr, eBp)));
    case (kind)
      3'd0, 3'd1: ok = 1'b1;
      3'd2:       ok = eWel && !expHpm();
      3'd3, 3'd4: ok = eWel && !expHit(addr, eBp);
      default:    ok = 1'b0;
    endcase
    @(negedge clk);
    cmdValid = 1'b0;
    check("R11 accept", 32'(cmdAccept), 32'(ok));
    check("R11 reject", 32'(cmdReject), 32'(!ok));
    case (kind)
      3'd0: eWel = 1'b1;
      3'd1: eWel = 1'b0;
      3'd2: begin
        if (ok) begin eLock = data[7]; eBp = data[5:2]; end
        eWel = 1'b0;
      end
      3'd3, 3'd4: eWel = 1'b0;
      default: ;
    endcase
    check("R2/R4/R5 statusWord", 32'(statusWord), 32'(expStatus()));
    settle();
  endtask

  task automatic setPins(logic wp, logic quad);
    @(negedge clk);
    wpN = wp; quadMode = quad;
    settle();
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 statusWord", 32'(statusWord), 32'h0);
    check("R1 hpmActive", 32'(hpmActive), 32'h0);
    check("R1 accept/reject", 32'({cmdAccept, cmdReject}), 32'h0);
    check("R1 srLocked", 32'(srLocked), 32'h1);
    rstN = 1'b1;
    settle();

    // R2 latch set and clear
    issue(3'd0, '0, '0);
    issue(3'd1, '0, '0);
    // R4 program without latch rejected, with latch accepted
    issue(3'd3, 21'h100, '0);
    issue(3'd0, '0, '0);
    issue(3'd3, 21'h100, '0);
    // R3 sweep every protect code over block edges
    for (int c = 0; c < 16; c++) begin
      issue(3'd0, '0, '0);
      issue(3'd2, '0, 8'(c << 2));
      for (int b = 0; b < 32; b += 3) issue(3'd4, ADDR_W'(b) << BLOCK_W, '0);
      issue(3'd3, '1, '0);
    end
    // R9 lock bit set with pin high stays writable
    issue(3'd0, '0, '0);
    issue(3'd2, '0, 8'h80);
    issue(3'd0, '0, '0);
    issue(3'd2, '0, 8'h84);
    // R6 pin low after lock bit
    setPins(1'b0, 1'b0);
    // R5 status write rejected under hardware protection
    issue(3'd0, '0, '0);
    issue(3'd2, '0, 8'h00);
    // R8 quad mode lifts protection, pin ignored
    setPins(1'b0, 1'b1);
    setPins(1'b1, 1'b1);
    setPins(1'b0, 1'b1);
    setPins(1'b0, 1'b0);
    // R7 only pin high exits
    issue(3'd0, '0, '0);
    issue(3'd2, '0, 8'h00);
    setPins(1'b1, 1'b0);
    issue(3'd0, '0, '0);
    issue(3'd2, '0, 8'h00);
    // R6 other order: pin low first, then lock bit
    setPins(1'b0, 1'b0);
    issue(3'd0, '0, '0);
    issue(3'd2, '0, 8'h88);
    // R11 undefined codes
    issue(3'd5, '0, '0);
    issue(3'd7, '0, '0);
    setPins(1'b1, 1'b0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) setPins(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
      else if (r < 4) issue(3'd0, '0, '0);
      else issue(3'($urandom_range(0, 7)), ADDR_W'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule